// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serializes bytes onto one asynchronous output line. A byte written by software first goes into a one-entry holding register. On a baud tick it then moves into a shift register, which sends a start bit (0), the data bits least significant first, an optional ninth bit and a stop bit (1). The line sits at 1 between frames. The line moves only on clock edges where the external baud tick is high. Baud-rate generation, reception and bus decoding are left to the surrounding logic.

Two controls set the behaviour. The frame-length select adds a ninth bit after the data. The ninth bit comes from its own one-bit register, which has its own write strobe. The buffering enable changes three things: when a write is accepted, when the ninth bit is sampled, and what raises the transmit interrupt flag. With buffering on, the ninth bit is captured together with the byte, and the flag rises as soon as the holding register empties into the shifter. A second byte can therefore be queued while the first is still being sent, and it follows with no idle bit between the frames. With buffering off, the ninth bit is read from its register when that bit position begins, and the flag rises when the stop bit completes. Software clears the interrupt flag with a write-one strobe. A write that cannot be taken is dropped and sets a sticky overrun bit.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_irq` is 0 and `overrun` is 0. `txd` stays 1 whenever no frame is being shifted.
- R2: With `nine_mode` = 0, a frame is start bit 0, then 8 data bits least significant first, then stop bit 1. Each bit is held from one baud tick to the next. The start bit appears on the first baud tick after the byte is written.
- R3: With `nine_mode` = 1, the ninth bit is sent between the last data bit and the stop bit, giving 11 bit periods.
- R4: With `dbuf_en` = 1, the ninth bit is the value of the ninth-bit register at the cycle of the data write. Changing that register afterwards does not alter the queued frame.
- R5: With `dbuf_en` = 0, the ninth bit is read from the ninth-bit register on the tick that starts that bit position. A ninth-bit write made after the data write is therefore sent.
- R6: With `dbuf_en` = 1, `tx_irq` is 1 in the cycle after the holding register moves into the shifter. It is not set at the end of the frame.
- R7: With `dbuf_en` = 0, `tx_irq` stays 0 while the frame is sent. It becomes 1 in the cycle after the tick that ends the stop bit.
- R8: If a byte is waiting when a stop bit ends, its start bit goes out on that same tick, with no idle bit between the frames.
- R9: A data write is dropped and sets `overrun`, which stays set until reset. With `dbuf_en` = 1 this happens when the holding register is full. With `dbuf_en` = 0 it happens when a frame is waiting or being shifted. A dropped byte is never sent.
- R10: A cycle with `irq_clr` = 1 clears `tx_irq`. If a set event occurs in the same cycle, the set wins.
- R11: `txd` changes only at clock edges where `baud_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_stb | input | 1 | Data write strobe |
| wr_data | input | DATA_W | Byte to send |
| bit9_wr | input | 1 | Write strobe for the ninth-bit register |
| bit9_val | input | 1 | New ninth-bit value |
| dbuf_en | input | 1 | 1 selects buffered operation |
| nine_mode | input | 1 | 1 adds the ninth bit to the frame |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| txd | output | 1 | Serial output line |
| tx_irq | output | 1 | Transmit interrupt flag |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
All three outputs are registers. A data write or a flag clear shows its effect one clock edge after the strobe. A line bit or an interrupt set by the shifter shows its effect one clock edge after the edge that carries the baud tick. The bench changes inputs and samples outputs only on falling edges. Each tick is a one-cycle pulse followed by two quiet cycles, so every sample is taken several cycles after the edge that produced it, and at a point where R11 requires the line to be steady.

// File: rtl/dbuf_uart_tx_pkg.sv
`timescale 1ns/1ps
package dbuf_uart_tx_pkg;
   localparam logic LINE_START = 1'b0;
   localparam logic LINE_STOP  = 1'b1;
   localparam int   MIN_DATA_W = 5;
   localparam int   MAX_DATA_W = 16;

   // index of the stop bit: start at 0, data at 1..dw, optional ninth bit
   function automatic int frame_last(input int dw, input logic nine);
      return dw + 1 + (nine ? 1 : 0);
   endfunction
endpackage

// File: rtl/dbuf_uart_tx_hold.sv
`timescale 1ns/1ps
module dbuf_uart_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_b9,
   input  logic              wr_live,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] q_data,
   output logic              q_b9,
   output logic              q_live
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full   <= 1'b0;
         q_data <= '0;
         q_b9   <= 1'b0;
         q_live <= 1'b0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_ok) begin
         full   <= 1'b1;
         q_data <= wr_data;
         q_b9   <= wr_b9;
         q_live <= wr_live;
      end
   end

   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      full && !take |=> full && $stable(q_data) && $stable(q_b9)); // R4
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !wr_ok); // R9
endmodule

// File: rtl/dbuf_uart_tx_shift.sv
`timescale 1ns/1ps
module dbuf_uart_tx_shift
   import dbuf_uart_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_b9,
   input  logic              ld_live,
   input  logic              ld_nine,
   input  logic              live_b9,
   output logic              txd,
   output logic              busy,
   output logic              can_load,
   output logic              frame_end
);
   localparam int IDX_W = $clog2(DATA_W + 3);
   localparam logic [IDX_W-1:0] LAST8  = IDX_W'(frame_last(DATA_W, 1'b0));
   localparam logic [IDX_W-1:0] LAST9  = IDX_W'(frame_last(DATA_W, 1'b1));
   localparam logic [IDX_W-1:0] DATA_I = IDX_W'(DATA_W);

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] sh;
   logic              fr_nine, fr_b9, fr_live, txd_q, at_last;

   assign at_last   = busy && (idx == (fr_nine ? LAST9 : LAST8));
   assign can_load  = tick && (!busy || at_last);
   assign frame_end = tick && at_last;
   assign txd       = txd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         sh      <= '0;
         fr_nine <= 1'b0;
         fr_b9   <= 1'b0;
         fr_live <= 1'b0;
         txd_q   <= LINE_STOP;
      end else if (tick) begin
         if (load) begin
            busy    <= 1'b1;
            idx     <= '0;
            sh      <= ld_data;
            fr_nine <= ld_nine;
            fr_b9   <= ld_b9;
            fr_live <= ld_live;
            txd_q   <= LINE_START;
         end else if (busy) begin
            if (at_last) begin
               busy  <= 1'b0;
               idx   <= '0;
               txd_q <= LINE_STOP;
            end else begin
               idx <= idx + IDX_W'(1);
               if (idx < DATA_I) begin
                  txd_q <= sh[0];
                  sh    <= sh >> 1;
               end else if (fr_nine && idx == DATA_I) begin
                  txd_q <= fr_live ? live_b9 : fr_b9;
               end else begin
                  txd_q <= LINE_STOP;
               end
            end
         end
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd_q); // R1
   AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      tick && load |=> busy && !txd_q); // R2
   AST_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd_q)); // R11
   AST_LOAD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> tick && (!busy || at_last)); // R8
endmodule

// File: rtl/dbuf_uart_tx_flag.sv
`timescale 1ns/1ps
module dbuf_uart_tx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)      flag <= 1'b0;
      else if (set_ev) flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> flag); // R10
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag); // R10
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set_ev |=> !flag); // R10
endmodule

// File: rtl/dbuf_uart_tx.sv
`timescale 1ns/1ps
module dbuf_uart_tx
   import dbuf_uart_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bit9_wr,
   input  logic              bit9_val,
   input  logic              dbuf_en,
   input  logic              nine_mode,
   input  logic              irq_clr,
   output logic              txd,
   output logic              tx_irq,
   output logic              overrun
);
   generate
      if (DATA_W < MIN_DATA_W || DATA_W > MAX_DATA_W) begin : g_bad_width
         $error("dbuf_uart_tx: DATA_W out of range");
      end
   endgenerate

   logic              b9_reg;
   logic              hold_full, hold_b9, hold_live;
   logic [DATA_W-1:0] hold_data;
   logic              busy, can_load, frame_end;
   logic              accept, reject, take, irq_set;

   always_ff @(posedge clk) begin
      if (!rst_n)       b9_reg <= 1'b0;
      else if (bit9_wr) b9_reg <= bit9_val;
   end

   assign accept  = wr_stb && (dbuf_en ? !hold_full : (!hold_full && !busy));
   assign reject  = wr_stb && !accept;
   assign take    = can_load && hold_full;
   assign irq_set = dbuf_en ? take : frame_end;

   dbuf_uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ok   (accept),
      .wr_data (wr_data),
      .wr_b9   (b9_reg),
      .wr_live (!dbuf_en),
      .take    (take),
      .full    (hold_full),
      .q_data  (hold_data),
      .q_b9    (hold_b9),
      .q_live  (hold_live)
   );

   dbuf_uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .load      (take),
      .ld_data   (hold_data),
      .ld_b9     (hold_b9),
      .ld_live   (hold_live),
      .ld_nine   (nine_mode),
      .live_b9   (b9_reg),
      .txd       (txd),
      .busy      (busy),
      .can_load  (can_load),
      .frame_end (frame_end)
   );

   dbuf_uart_tx_flag u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (irq_set),
      .clr    (irq_clr),
      .flag   (tx_irq)
   );

   dbuf_uart_tx_flag u_ovr (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (reject),
      .clr    (1'b0),
      .flag   (overrun)
   );

   AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end && hold_full |-> take); // R8
   AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && dbuf_en && hold_full |=> overrun); // R9
   AST_BUF_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      dbuf_en && take |=> tx_irq); // R6
endmodule

// File: tb/dbuf_uart_tx_bench.sv
`timescale 1ns/1ps
module dbuf_uart_tx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = '0;
   logic       bit9_wr = 1'b0;
   logic       bit9_val = 1'b0;
   logic       dbuf_en = 1'b0;
   logic       nine_mode = 1'b0;
   logic       irq_clr = 1'b0;
   logic       txd, tx_irq, overrun;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dbuf_uart_tx #(.DATA_W(8)) u_dbuf_uart_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_stb(wr_stb),
      .wr_data(wr_data), .bit9_wr(bit9_wr), .bit9_val(bit9_val),
      .dbuf_en(dbuf_en), .nine_mode(nine_mode), .irq_clr(irq_clr),
      .txd(txd), .tx_irq(tx_irq), .overrun(overrun)
   );

   // {dbuf_en, nine_mode, ninth bit, data}
   localparam logic [10:0] VEC [6] = '{
      11'b000_10100101,
      11'b011_00111100,
      11'b010_11000011,
      11'b101_01011010,
      11'b111_10000001,
      11'b110_01111110
   };

   task automatic chk(input logic act, input logic exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic tick();
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      wr_stb = 1'b1; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic set9(input logic v);
      bit9_wr = 1'b1; bit9_val = v;
      @(negedge clk);
      bit9_wr = 1'b0;
   endtask

   task automatic clr_irq();
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      chk(txd, 1'b1, "R1 reset txd");
      chk(tx_irq, 1'b0, "R1 reset irq");
      chk(overrun, 1'b0, "R1 reset overrun");

      // table walk: single frames, R2..R7
      for (int v = 0; v < 6; v++) begin
         logic        vb, vn, v9;
         logic [7:0]  vd;
         logic [10:0] fr;
         int          len;
         {vb, vn, v9, vd} = VEC[v];
         dbuf_en = vb; nine_mode = vn;
         clr_irq();
         set9(vb ? v9 : ~v9);
         wr(vd);
         set9(vb ? ~v9 : v9);   // R4 late change ignored, R5 late write used
         fr = '1;
         fr[0] = 1'b0;
         for (int i = 0; i < 8; i++) fr[1+i] = vd[i];
         if (vn) fr[9] = v9;
         len = vn ? 11 : 10;
         for (int k = 0; k < len; k++) begin
            tick();
            chk(txd, fr[k], $sformatf("R2/R3/R4/R5 vec%0d bit%0d", v, k));
            if (k == 0 || k == len - 1)
               chk(tx_irq, vb, $sformatf("R6/R7 vec%0d irq bit%0d", v, k));
         end
         tick();
         chk(txd, 1'b1, $sformatf("R1 vec%0d idle", v));
         chk(tx_irq, 1'b1, $sformatf("R6/R7 vec%0d irq end", v));
      end

      // buffered back-to-back with a dropped third write
      do_reset();
      dbuf_en = 1'b1; nine_mode = 1'b0;
      wr(8'h96);
      tick();
      chk(txd, 1'b0, "R2 first start");
      chk(tx_irq, 1'b1, "R6 irq on buffer free");
      clr_irq();
      chk(tx_irq, 1'b0, "R10 cleared");
      wr(8'h0F);
      chk(overrun, 1'b0, "R9 no overrun with room");
      wr(8'hF0);
      chk(overrun, 1'b1, "R9 overrun when full");
      for (int k = 1; k < 10; k++) begin
         tick();
         chk(txd, (k == 9) ? 1'b1 : logic'(8'h96 >> (k - 1)), $sformatf("R2 frameA bit%0d", k));
      end
      chk(tx_irq, 1'b0, "R6 no irq at frame end");
      tick();
      chk(txd, 1'b0, "R8 start with no idle bit");
      chk(tx_irq, 1'b1, "R6 irq at second load");
      for (int k = 1; k < 10; k++) begin
         tick();
         chk(txd, (k == 9) ? 1'b1 : logic'(8'h0F >> (k - 1)), $sformatf("R9 frameB bit%0d", k));
      end
      tick();
      chk(txd, 1'b1, "R9 dropped byte not sent");
      tick();
      chk(txd, 1'b1, "R9 line stays idle");
      chk(overrun, 1'b1, "R9 overrun sticky");

      // unbuffered: write during shifting is dropped
      do_reset();
      dbuf_en = 1'b0; nine_mode = 1'b0;
      wr(8'h55);
      tick();
      wr(8'hAA);
      chk(overrun, 1'b1, "R9 unbuffered busy drop");
      for (int k = 1; k < 11; k++) tick();
      chk(txd, 1'b1, "R9 unbuffered idle after frame");
      chk(tx_irq, 1'b1, "R7 irq after stop");
      tick();
      chk(txd, 1'b1, "R9 unbuffered dropped byte not sent");
      clr_irq();
      chk(tx_irq, 1'b0, "R10 w1c");

      // set wins over clear, line steady without ticks
      dbuf_en = 1'b1;
      wr(8'h01);
      baud_tick = 1'b1; irq_clr = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0; irq_clr = 1'b0;
      chk(tx_irq, 1'b1, "R10 set wins");
      repeat (6) @(negedge clk);
      chk(txd, 1'b0, "R11 steady without tick");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule